// File: doc/BRIEF.md
# Preloaded Prescaler Time Base

This block is a 16-bit up-counting time base for a general-purpose timer. An input clock-enable tick is divided by a programmable prescaler. Each divided tick advances a counter from zero up to a reload limit. When the counter passes the limit it wraps to zero and raises an update flag.

The prescaler divisor and the reload limit are each held twice. Software writes a preload copy, and the logic uses an active copy. The active prescaler changes only when an update event occurs. An update event is a counter wrap, a software update-generate strobe, or an external trigger reset. A control bit decides whether the reload limit also waits for an update event or takes effect on the write.

Software reaches the block through a small synchronous register bus with word addresses. The register at word 0 is control: bit 0 enables the reload preload, and bit 1 mirrors the flag into the count readback. Word 1 is status, with the update flag in bit 0. Word 2 is the count, word 3 the prescaler preload and word 4 the reload preload. Read data follows the address in the same cycle. Writes take effect at the clock edge.

Top module: `tmr_timebase`

## Requirements
- R1: After reset the count reads 0, the prescaler reads 0, the reload reads 0x0000FFFF, and status bit 0 (update flag) reads 0.
- R2: With active prescaler value P, the counter advances once for every P+1 input ticks. Counting starts from a cleared prescaler count.
- R3: A write to the prescaler (word 3) changes only the preload copy, and reading word 3 returns it. The divisor in use changes only at the next update event.
- R4: With a nonzero active reload value A, the counter counts 0..A. On the next counter tick it returns to 0 and sets the update flag.
- R5: A software update-generate or trigger-reset pulse loads the active copies from their preloads. In the same cycle it clears the counter and the prescaler count, and it sets the update flag.
- R6: While the active reload value is zero, the counter holds its value.
- R7: With control bit 0 set, a write to the reload (word 4) takes effect only at the next update event. With control bit 0 clear, it takes effect at once.
- R8: Reading word 2 returns the count in bits 15:0 and zeros in bits 30:16. Bit 31 is the update flag when control bit 1 is set, and 0 when it is clear.
- R9: Writing word 1 with bit 0 equal to 0 clears the update flag. Writing bit 0 equal to 1 leaves the flag unchanged. A flag-setting event in the same cycle wins over the clear.
- R10: A write to word 2 loads the counter with bits 15:0 of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Prescaler input clock enable |
| swUpdate | input | 1 | Software update-generate strobe |
| trigReset | input | 1 | Trigger-controller reset strobe |
| busWe | input | 1 | Register write enable |
| busAddr | input | 3 | Register word address |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data for busAddr |
| updFlag | output | 1 | Update interrupt flag |

## Verification
The assertions assume that the strobes and bus writes are single-cycle pulses sampled on the rising edge. They also assume that a counter write and an update strobe do not arrive together unless the update is meant to win. The hold and wrap properties exclude the cycles in which a bus write or a forced update touches the counter. The bench drives every input on the falling edge and pulses each strobe for exactly one cycle. Before each vector it returns the block to a known state with a software update, and it clears the flag through the status register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_STATUS = 1;
  localparam int ADDR_COUNT  = 2;
  localparam int ADDR_PSC    = 3;
  localparam int ADDR_RELOAD = 4;

  typedef struct packed {
    logic forceUpd;   // software or trigger update: clear counts, load shadows
    logic cntWr;      // bus write to the counter
    logic arrDirect;  // reload write that bypasses the preload
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              swUpdate,
  input  logic              trigReset,
  input  logic              ovfEvt,
  input  logic [CNT_W-1:0]  cntVal,
  output tmrStrobe_t        strobe,
  output logic [CNT_W-1:0]  wrValue,
  output logic [CNT_W-1:0]  pscPreload,
  output logic [CNT_W-1:0]  arrPreload,
  output logic              flag,
  output logic [DATA_W-1:0] rdata
);
  logic arpe, mirrorEn;
  logic wrCtrl, wrStatus, wrCount, wrPsc, wrReload;
  logic setFlag;
  logic unusedWdata;

  assign unusedWdata = ^busWdata[DATA_W-1:CNT_W];
  assign wrCtrl   = busWe && (busAddr == ADDR_W'(ADDR_CTRL));
  assign wrStatus = busWe && (busAddr == ADDR_W'(ADDR_STATUS));
  assign wrCount  = busWe && (busAddr == ADDR_W'(ADDR_COUNT));
  assign wrPsc    = busWe && (busAddr == ADDR_W'(ADDR_PSC));
  assign wrReload = busWe && (busAddr == ADDR_W'(ADDR_RELOAD));

  assign wrValue          = busWdata[CNT_W-1:0];
  assign strobe.forceUpd  = swUpdate | trigReset;
  assign strobe.cntWr     = wrCount;
  assign strobe.arrDirect = wrReload && !arpe;
  assign setFlag          = ovfEvt | strobe.forceUpd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      arpe       <= 1'b0;
      mirrorEn   <= 1'b0;
      pscPreload <= '0;
      arrPreload <= '1;
      flag       <= 1'b0;
    end else begin
      if (wrCtrl) begin
        arpe     <= busWdata[0];
        mirrorEn <= busWdata[1];
      end
      if (wrPsc)    pscPreload <= busWdata[CNT_W-1:0];
      if (wrReload) arrPreload <= busWdata[CNT_W-1:0];
      if (setFlag)                       flag <= 1'b1;
      else if (wrStatus && !busWdata[0]) flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (busAddr)
      ADDR_W'(ADDR_CTRL):   rdata[1:0] = {mirrorEn, arpe};
      ADDR_W'(ADDR_STATUS): rdata[0] = flag;
      ADDR_W'(ADDR_COUNT): begin
        rdata[CNT_W-1:0]  = cntVal;
        rdata[DATA_W-1]   = mirrorEn & flag;
      end
      ADDR_W'(ADDR_PSC):    rdata[CNT_W-1:0] = pscPreload;
      ADDR_W'(ADDR_RELOAD): rdata[CNT_W-1:0] = arrPreload;
      default:              rdata = '0;
    endcase
  end

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    setFlag |=> flag);
  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!setFlag && !wrStatus) |=> $stable(flag));
  assert_rsv_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(ADDR_COUNT)) |-> (rdata[DATA_W-2:CNT_W] == '0));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] wrValue,
  input  logic [CNT_W-1:0] pscPreload,
  input  logic [CNT_W-1:0] arrPreload,
  output logic [CNT_W-1:0] cntVal,
  output logic             ovfEvt
);
  logic [CNT_W-1:0] psCnt, psActive, arrActive, cnt;
  logic cntTick, arrZero, updEvt;

  assign cntTick = tickIn && (psCnt == psActive);
  assign arrZero = (arrActive == '0);
  assign ovfEvt  = cntTick && !arrZero && (cnt == arrActive)
                   && !strobe.forceUpd && !strobe.cntWr;
  assign updEvt  = ovfEvt | strobe.forceUpd;
  assign cntVal  = cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psCnt     <= '0;
      psActive  <= '0;
      arrActive <= '1;
      cnt       <= '0;
    end else begin
      if (strobe.forceUpd)  psCnt <= '0;
      else if (tickIn)      psCnt <= cntTick ? '0 : psCnt + 1'b1;

      if (updEvt) psActive <= pscPreload;

      if (strobe.arrDirect) arrActive <= wrValue;
      else if (updEvt)      arrActive <= arrPreload;

      if (strobe.forceUpd)          cnt <= '0;
      else if (strobe.cntWr)        cnt <= wrValue;
      else if (cntTick && !arrZero) cnt <= (cnt == arrActive) ? '0 : cnt + 1'b1;
    end
  end

  assert_hold_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (arrZero && !strobe.forceUpd && !strobe.cntWr) |=> $stable(cnt));
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt |=> (cnt == '0));
  assert_force_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.forceUpd |=> (cnt == '0 && psCnt == '0 && psActive == $past(pscPreload)));
  assert_tick_rate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!cntTick && !strobe.forceUpd && !strobe.cntWr) |=> $stable(cnt));
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              swUpdate,
  input  logic              trigReset,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              updFlag
);
  tmrStrobe_t       strobe;
  logic [CNT_W-1:0] wrValue, pscPreload, arrPreload, cntVal;
  logic             ovfEvt;

  tmr_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .swUpdate(swUpdate), .trigReset(trigReset),
    .ovfEvt(ovfEvt), .cntVal(cntVal), .strobe(strobe), .wrValue(wrValue),
    .pscPreload(pscPreload), .arrPreload(arrPreload), .flag(updFlag),
    .rdata(busRdata)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .strobe(strobe),
    .wrValue(wrValue), .pscPreload(pscPreload), .arrPreload(arrPreload),
    .cntVal(cntVal), .ovfEvt(ovfEvt)
  );
endmodule

// File: tb/tmr_timebase_tb.sv
module tmr_timebase_tb;
  localparam int CLK_PERIOD = 10;
  // columns: prescaler, reload, input ticks, expected count, expected flag
  localparam int NVEC = 8;
  localparam int VEC[NVEC][5] = '{
    '{0, 5,   3, 3, 0},
    '{0, 5,   6, 0, 1},
    '{2, 10,  7, 2, 0},
    '{1, 3,   9, 0, 1},
    '{3, 100, 20, 5, 0},
    '{0, 0,   5, 0, 0},
    '{4, 2,   16, 0, 1},
    '{0, 1,   5, 1, 1}
  };

  logic clk = 0, rstN = 0, tickIn = 0, swUpdate = 0, trigReset = 0, busWe = 0;
  logic [2:0]  busAddr = 0;
  logic [31:0] busWdata = 0;
  logic [31:0] busRdata;
  logic        updFlag;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  tmr_timebase u_dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .swUpdate(swUpdate),
    .trigReset(trigReset), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .updFlag(updFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input int a, input logic [31:0] d);
    busAddr = a[2:0]; busWdata = d; busWe = 1;
    @(negedge clk);
    busWe = 0;
  endtask

  task automatic busRead(input int a, output logic [31:0] d);
    busAddr = a[2:0];
    #1 d = busRdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      tickIn = 1;
      repeat (n) @(negedge clk);
      tickIn = 0;
    end
  endtask

  task automatic pulseSw();
    swUpdate = 1; @(negedge clk); swUpdate = 0;
  endtask

  task automatic pulseTrig();
    trigReset = 1; @(negedge clk); trigReset = 0;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    busRead(2, rd); check("R1 count", rd, 32'h0);
    busRead(3, rd); check("R1 prescaler", rd, 32'h0);
    busRead(4, rd); check("R1 reload", rd, 32'h0000FFFF);
    busRead(1, rd); check("R1 flag", rd, 32'h0);

    // Vector table: R2, R4, R6
    for (int v = 0; v < NVEC; v++) begin
      busWrite(0, 32'h0);
      busWrite(3, VEC[v][0]);
      busWrite(4, VEC[v][1]);
      pulseSw();
      busWrite(1, 32'h0);
      ticks(VEC[v][2]);
      busRead(2, rd); check("R2/R4/R6 vector count", rd, VEC[v][3]);
      busRead(1, rd); check("R4 vector flag", rd, VEC[v][4]);
    end

    // R3 prescaler preload waits for update
    busWrite(3, 0); busWrite(4, 100); pulseSw(); busWrite(1, 0);
    busWrite(3, 3);
    ticks(2);
    busRead(2, rd); check("R3 old divisor kept", rd, 2);
    busRead(3, rd); check("R3 preload readback", rd, 3);
    pulseSw();
    ticks(4);
    busRead(2, rd); check("R3 new divisor after update", rd, 1);

    // R5 trigger reset clears prescaler count and counter, sets flag
    busWrite(1, 0);
    ticks(6);  // count 2, prescaler count 2
    pulseTrig();
    busRead(2, rd); check("R5 counter cleared", rd, 0);
    busRead(1, rd); check("R5 flag set", rd, 1);
    ticks(3);
    busRead(2, rd); check("R5 prescaler count cleared", rd, 0);
    ticks(1);
    busRead(2, rd); check("R5 first tick after clear", rd, 1);

    // R7 reload preload enabled
    busWrite(3, 0); busWrite(4, 100); pulseSw(); busWrite(1, 0);
    busWrite(0, 1);
    busWrite(4, 2);
    ticks(5);
    busRead(2, rd); check("R7 buffered reload not yet used", rd, 5);
    busRead(1, rd); check("R7 no wrap at buffered value", rd, 0);
    pulseSw(); busWrite(1, 0);
    ticks(3);
    busRead(1, rd); check("R7 new reload after update", rd, 1);
    // R7 preload disabled: immediate
    busWrite(0, 0); busWrite(4, 100); pulseSw(); busWrite(1, 0);
    busWrite(4, 1);
    ticks(2);
    busRead(1, rd); check("R7 immediate reload", rd, 1);

    // R9 flag write semantics
    busWrite(1, 1);
    busRead(1, rd); check("R9 write 1 keeps set flag", rd, 1);
    busWrite(1, 0);
    busRead(1, rd); check("R9 write 0 clears", rd, 0);
    busWrite(1, 1);
    busRead(1, rd); check("R9 write 1 does not set", rd, 0);

    // R10 counter write, R8 readback mirror
    busWrite(4, 1000);
    busWrite(2, 32'hABCD_0007);
    busRead(2, rd); check("R10 counter write", rd, 32'h0000_0007);
    pulseSw();
    busWrite(2, 9);
    busWrite(0, 2);
    busRead(2, rd); check("R8 mirror on", rd, 32'h8000_0009);
    busWrite(0, 0);
    busRead(2, rd); check("R8 mirror off", rd, 32'h0000_0009);

    finish();
  end
endmodule